// File: doc/BRIEF.md
# DRAM Address Latch and Row/Column Multiplexer

This block sits between a host address bus and the multiplexed address pins of a DRAM array. When an access starts, a strobe captures three fields of the host address into separate holding registers: the bank number, the row and the column. A row/column select from the external timing sequencer then picks which field drives the shared DRAM address output. The bank number drives a separate bank-select output.

During a static-column or page-mode burst, a column-increment input steps the held column by one on each clock. The column wraps within its own field and never carries into the row.

Two further features are set by configuration:
- A fall-through setting bypasses the holding registers, so the outputs track the host address directly.
- A programmable column-hold count lets the multiplexer return to the row address before the column phase ends. A flag reports this, so the sequencer can start the next bank's access early (address pipelining).

Top module: `dram_addr_mux`

## Requirements
- R1: While `latch_stb` is high at a rising clock edge, the bank, row and column registers load from `host_addr`. The layout is `{bank, row, col}`, with the column in the least significant `COL_W` bits, the row in the next `ROW_W` bits and the bank in the top `BANK_W` bits. When `latch_stb` is low and no increment applies, all three registers hold.
- R2: In holding mode (`cfg_fall_through` = 0), each clock edge with `col_inc` high and `latch_stb` low adds one to the held column. The column wraps from 2^COL_W-1 to 0, and the row and bank are left unchanged.
- R3: When `latch_stb` and `col_inc` are both high at the same edge, the capture wins and the column takes the host value without being incremented.
- R4: While `sel_col` is low, `dram_addr` shows the row, zero-extended to the output width, and `row_again` is 0.
- R5: When `cfg_hold` = 0, `dram_addr` shows the column for the whole time `sel_col` is high, and `row_again` stays 0.
- R6: When `cfg_hold` = N with N > 0, `dram_addr` shows the column for the first N cycles that `sel_col` is high. From then until `sel_col` falls, it shows the row and `row_again` is 1.
- R7: While `cfg_fall_through` = 1, `dram_addr` and `bank_sel` are taken from `host_addr` in the same cycle, and `col_inc` has no effect on the held column.
- R8: A synchronous active-high `rst` clears the bank, row and column registers and the hold timer. With `sel_col` low, the outputs are then `dram_addr` = 0, `bank_sel` = 0 and `row_again` = 0.
- R9: `bank_sel` is `BANK_W` bits wide (default 2, so four banks) and shows the held bank number in holding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | BANK_W+ROW_W+COL_W | Host address, laid out as {bank, row, col} |
| latch_stb | input | 1 | Capture the host address fields |
| col_inc | input | 1 | Step the held column by one |
| sel_col | input | 1 | From the sequencer: 1 = column phase, 0 = row phase |
| cfg_fall_through | input | 1 | 1 = transparent latches, 0 = edge-captured |
| cfg_hold | input | HOLD_W | Column hold in cycles; 0 disables the early return to row |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| bank_sel | output | BANK_W | Bank number |
| row_again | output | 1 | Row address shown again during the column phase |

## Verification
The bench targets the following corner cases. Each is listed with the symptom a faulty design would show.

- **Column wrap.** The bench loads the column at its top value and increments it. A design that lets the carry spill would corrupt the row, and a design whose width is wrong would show 512.
- **Capture together with increment.** A design with the wrong priority would present host column plus one.
- **Column-hold window.** The bench runs this with several counts, including 0 and 1. An off-by-one timer would hand back the row a cycle early or late, and a timer that ignores 0 would raise `row_again` with pipelining disabled.
- **Fall-through mode.** The bench drives `col_inc` during fall-through, then returns to holding mode and reads the held column back. A design that still increments in fall-through mode would show a shifted column at that point.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic {
    MUX_ROW = 1'b0,
    MUX_COL = 1'b1
  } mux_sel_e;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dam_field_latch.sv
module dam_field_latch #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [BANK_W-1:0] bank_d,
  input  logic [ROW_W-1:0]  row_d,
  input  logic [COL_W-1:0]  col_d,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q
);

  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (load) begin
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end else if (step) begin
      col_q  <= col_q + COL_ONE;
    end
  end

endmodule

// File: rtl/dam_hold_timer.sv
module dam_hold_timer #(
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic [HOLD_W-1:0] cnt,
  output logic              done
);

  logic enabled;

  assign enabled = (hold_cfg != '0);
  assign done    = strobe && enabled && (cnt >= hold_cfg);

  always_ff @(posedge clk) begin
    if (rst || !strobe) begin
      cnt <= '0;
    end else if (enabled && (cnt < hold_cfg)) begin
      cnt <= cnt + HOLD_W'(1);
    end
  end

endmodule

// File: rtl/dam_out_mux.sv
module dam_out_mux
  import dam_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 9,
  parameter int OUT_W = max_w(ROW_W, COL_W)
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  mux_sel_e         sel,
  output logic [OUT_W-1:0] out
);

  logic [OUT_W-1:0] row_ext;
  logic [OUT_W-1:0] col_ext;

  generate
    if (ROW_W < OUT_W) begin : g_row_pad
      assign row_ext = {{(OUT_W-ROW_W){1'b0}}, row};
    end else begin : g_row_full
      assign row_ext = row;
    end
    if (COL_W < OUT_W) begin : g_col_pad
      assign col_ext = {{(OUT_W-COL_W){1'b0}}, col};
    end else begin : g_col_full
      assign col_ext = col;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      MUX_COL: out = col_ext;
      default: out = row_ext;
    endcase
  end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dam_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int HOLD_W = 3,
  parameter int ADDR_W = BANK_W + ROW_W + COL_W,
  parameter int OUT_W  = max_w(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              latch_stb,
  input  logic              col_inc,
  input  logic              sel_col,
  input  logic              cfg_fall_through,
  input  logic [HOLD_W-1:0] cfg_hold,
  output logic [OUT_W-1:0]  dram_addr,
  output logic [BANK_W-1:0] bank_sel,
  output logic              row_again
);

  localparam int ROW_LSB  = COL_W;
  localparam int BANK_LSB = COL_W + ROW_W;

  logic [BANK_W-1:0] host_bank;
  logic [ROW_W-1:0]  host_row;
  logic [COL_W-1:0]  host_col;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_done;
  logic              step_col;
  logic [ROW_W-1:0]  row_src;
  logic [COL_W-1:0]  col_src;
  mux_sel_e          mux_sel;

  assign host_col  = host_addr[COL_W-1:0];
  assign host_row  = host_addr[ROW_LSB +: ROW_W];
  assign host_bank = host_addr[BANK_LSB +: BANK_W];

  assign step_col = col_inc && !cfg_fall_through;

  dam_field_latch #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .load   (latch_stb),
    .step   (step_col),
    .bank_d (host_bank),
    .row_d  (host_row),
    .col_d  (host_col),
    .bank_q (bank_q),
    .row_q  (row_q),
    .col_q  (col_q)
  );

  dam_hold_timer #(
    .HOLD_W(HOLD_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .strobe   (sel_col),
    .hold_cfg (cfg_hold),
    .cnt      (hold_cnt),
    .done     (hold_done)
  );

  assign row_src  = cfg_fall_through ? host_row  : row_q;
  assign col_src  = cfg_fall_through ? host_col  : col_q;
  assign bank_sel = cfg_fall_through ? host_bank : bank_q;
  assign mux_sel  = (sel_col && !hold_done) ? MUX_COL : MUX_ROW;
  assign row_again = hold_done;

  dam_out_mux #(
    .ROW_W(ROW_W), .COL_W(COL_W), .OUT_W(OUT_W)
  ) u_mux (
    .row (row_src),
    .col (col_src),
    .sel (mux_sel),
    .out (dram_addr)
  );

endmodule

// File: rtl/dam_checker.sv
module dam_checker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int HOLD_W = 3,
  parameter int ADDR_W = BANK_W + ROW_W + COL_W,
  parameter int OUT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              latch_stb,
  input logic              col_inc,
  input logic              sel_col,
  input logic              cfg_fall_through,
  input logic [HOLD_W-1:0] cfg_hold,
  input logic [OUT_W-1:0]  dram_addr,
  input logic [BANK_W-1:0] bank_sel,
  input logic              row_again,
  input logic [BANK_W-1:0] bank_q,
  input logic [ROW_W-1:0]  row_q,
  input logic [COL_W-1:0]  col_q,
  input logic [HOLD_W-1:0] hold_cnt
);

  // R8
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (bank_q == '0 && row_q == '0 && col_q == '0 && hold_cnt == '0));

  // R1
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> ({bank_q, row_q, col_q} == $past(host_addr)));

  // R2
  a_r2_step_no_carry: assert property (@(posedge clk) disable iff (rst)
    (col_inc && !latch_stb && !cfg_fall_through) |=>
      ((col_q == $past(col_q) + COL_W'(1)) && (row_q == $past(row_q)) && (bank_q == $past(bank_q))));

  // R7
  a_r7_inc_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_fall_through && !latch_stb) |=> (col_q == $past(col_q)));

  // R7
  a_r7_bank_follows: assert property (@(posedge clk) disable iff (rst)
    cfg_fall_through |-> (bank_sel == host_addr[ADDR_W-1 -: BANK_W]));

  // R4
  a_r4_idle_no_flag: assert property (@(posedge clk) disable iff (rst)
    !sel_col |-> !row_again);

  // R5
  a_r5_zero_hold_no_flag: assert property (@(posedge clk) disable iff (rst)
    (sel_col && cfg_hold == '0) |-> !row_again);

  // R6
  a_r6_flag_shows_row: assert property (@(posedge clk) disable iff (rst)
    (row_again && !cfg_fall_through) |-> (dram_addr == OUT_W'(row_q)));

endmodule

bind dram_addr_mux dam_checker #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
  .HOLD_W(HOLD_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .latch_stb(latch_stb),
  .col_inc(col_inc), .sel_col(sel_col), .cfg_fall_through(cfg_fall_through),
  .cfg_hold(cfg_hold), .dram_addr(dram_addr), .bank_sel(bank_sel),
  .row_again(row_again), .bank_q(bank_q), .row_q(row_q), .col_q(col_q),
  .hold_cnt(hold_cnt)
);

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;

  localparam int BANK_W = 2;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 9;
  localparam int HOLD_W = 3;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int OUT_W  = 10;
  localparam int WDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              latch_stb = 1'b0;
  logic              col_inc = 1'b0;
  logic              sel_col = 1'b0;
  logic              cfg_fall_through = 1'b0;
  logic [HOLD_W-1:0] cfg_hold = '0;
  logic [OUT_W-1:0]  dram_addr;
  logic [BANK_W-1:0] bank_sel;
  logic              row_again;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_bank = 0, m_row = 0, m_col = 0, m_cnt = 0;

  always #5 clk = ~clk;

  dram_addr_mux u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .latch_stb(latch_stb),
    .col_inc(col_inc), .sel_col(sel_col), .cfg_fall_through(cfg_fall_through),
    .cfg_hold(cfg_hold), .dram_addr(dram_addr), .bank_sel(bank_sel),
    .row_again(row_again)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [ADDR_W-1:0] mk(input int b, input int r, input int c);
    return {BANK_W'(b), ROW_W'(r), COL_W'(c)};
  endfunction

  task automatic step(input string tag, input bit r, input bit stb, input bit inc,
                      input bit sel, input bit ft, input int hold, input logic [ADDR_W-1:0] a);
    int eb, er, ec, eaddr;
    bit done;
    @(negedge clk);
    rst = r; latch_stb = stb; col_inc = inc; sel_col = sel;
    cfg_fall_through = ft; cfg_hold = HOLD_W'(hold); host_addr = a;
    #1;
    if (ft) begin
      ec = int'(a[COL_W-1:0]);
      er = int'(a[COL_W +: ROW_W]);
      eb = int'(a[ADDR_W-1 -: BANK_W]);
    end else begin
      ec = m_col; er = m_row; eb = m_bank;
    end
    done  = sel && (hold != 0) && (m_cnt >= hold);
    eaddr = (sel && !done) ? ec : er;
    checks++;
    if (dram_addr !== OUT_W'(eaddr) || bank_sel !== BANK_W'(eb) || row_again !== done) begin
      errors++;
      $display("FAIL %s: addr=%0d bank=%0d flag=%0b expected addr=%0d bank=%0d flag=%0b",
               tag, dram_addr, bank_sel, row_again, eaddr, eb, done);
    end
    @(posedge clk);
    if (r) begin
      m_bank = 0; m_row = 0; m_col = 0; m_cnt = 0;
    end else begin
      if (stb) begin
        m_col  = int'(a[COL_W-1:0]);
        m_row  = int'(a[COL_W +: ROW_W]);
        m_bank = int'(a[ADDR_W-1 -: BANK_W]);
      end else if (inc && !ft) begin
        m_col = (m_col + 1) % (1 << COL_W);
      end
      if (!sel) m_cnt = 0;
      else if (hold != 0 && m_cnt < hold) m_cnt = m_cnt + 1;
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // R8: reset state
    step("R8", 1, 0, 0, 0, 0, 0, mk(3, 1000, 500));
    step("R8", 0, 0, 0, 0, 0, 0, mk(3, 1000, 500));
    // R1 / R4: capture and row phase
    step("R1", 0, 1, 0, 0, 0, 0, mk(2, 777, 123));
    step("R4", 0, 0, 0, 0, 0, 0, mk(1, 5, 6));
    step("R1", 0, 0, 0, 0, 0, 0, '0);
    // R5: no pipelining, column held for whole strobe
    for (int i = 0; i < 5; i++) step("R5", 0, 0, 0, 1, 0, 0, '0);
    step("R4", 0, 0, 0, 0, 0, 0, '0);
    // R6: hold counts 3, 1 and 7
    for (int i = 0; i < 6; i++) step("R6", 0, 0, 0, 1, 0, 3, '0);
    step("R6", 0, 0, 0, 0, 0, 3, '0);
    for (int i = 0; i < 3; i++) step("R6", 0, 0, 0, 1, 0, 1, '0);
    step("R6", 0, 0, 0, 0, 0, 1, '0);
    for (int i = 0; i < 9; i++) step("R6", 0, 0, 0, 1, 0, 7, '0);
    step("R6", 0, 0, 0, 0, 0, 7, '0);
    // R2: burst with column wrap, row must not change
    step("R2", 0, 1, 0, 0, 0, 0, mk(1, 1023, 509));
    for (int i = 0; i < 6; i++) step("R2", 0, 0, 1, 1, 0, 0, '0);
    step("R2", 0, 0, 0, 1, 0, 0, '0);
    step("R2", 0, 0, 0, 0, 0, 0, '0);
    // R3: capture wins over increment
    step("R3", 0, 1, 1, 0, 0, 0, mk(0, 42, 300));
    step("R3", 0, 0, 0, 1, 0, 0, '0);
    step("R3", 0, 0, 0, 0, 0, 0, '0);
    // R7: fall-through follows host, increment ignored
    step("R7", 0, 0, 1, 0, 1, 0, mk(3, 600, 11));
    step("R7", 0, 0, 1, 1, 1, 0, mk(2, 601, 12));
    step("R7", 0, 0, 1, 1, 1, 2, mk(1, 602, 13));
    step("R7", 0, 0, 1, 1, 1, 2, mk(0, 603, 14));
    step("R7", 0, 0, 1, 0, 1, 0, mk(3, 604, 15));
    step("R7", 0, 0, 0, 1, 0, 0, '0);
    step("R7", 0, 0, 0, 0, 0, 0, '0);
    // R9: all four bank values
    for (int b = 0; b < 4; b++) begin
      step("R9", 0, 1, 0, 0, 0, 0, mk(b, 100 + b, 200 + b));
      step("R9", 0, 0, 0, 1, 0, 0, '0);
    end
    // R8: reset mid-run
    step("R8", 1, 0, 0, 0, 0, 0, '0);
    step("R8", 0, 0, 0, 0, 0, 0, '0);
    step("R8", 0, 0, 0, 1, 0, 0, '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule